// File: doc/BRIEF.md
# Dual-Channel Compare Waveform Timer

This block is an 8-bit counter with two compare channels, A and B. Each channel turns the counter into a waveform on a single output pin. A 3-bit waveform-mode input selects how the counter runs: free-running up-count, clear-on-match (CTC), fast PWM, or phase-correct up/down PWM. In the PWM kinds the turn-around point (TOP) is either fixed at 0xFF or taken from channel A's compare value.

Each channel has a 2-bit output-action code. On every clock the block looks at the counter value, the count direction and whether the counter sits at TOP. From these it decides whether the pin is held, set, cleared or toggled. It also reports whether the channel has taken over the pin, and whether the pin is actually driven once the direction bit is applied.

Compare values arrive through a plain write strobe and data bus. The strobe is accepted on every cycle it is high, with no back-pressure. The mode and direction inputs are level controls.

Top module: `cmpwave_timer`

## Requirements
- R1: After reset, the counter is 0, both pins are 0 and both active compare values are 0. The phase-correct direction starts as counting up.
- R2: The counter steps on every clock according to the waveform mode. Codes 000, 100 and 110 free-run upward and wrap from 0xFF to 0. Code 010 (CTC) returns to 0 on the cycle after reaching TOP. Codes 011 and 111 (fast PWM) do the same. Codes 001 and 101 (phase-correct) count up to TOP, then down to 0, reversing at both ends; with TOP equal to 0 the counter stays at 0. TOP is the active channel A compare value for codes 010, 111 and 101, and 0xFF for all other codes.
- R3: In codes 000, 100, 110 and 010, a match (counter equals the channel's active compare value) acts according to the action code: 01 toggles the pin, 10 clears it, 11 sets it. Without a match the pin holds.
- R4: In fast PWM, action code 10 sets the pin at TOP and clears it on a match. Action code 11 clears it at TOP and sets it on a match. When both apply, the action at TOP wins.
- R5: In phase-correct PWM, action code 10 clears the pin on a match while counting up and sets it on a match while counting down. Action code 11 does the reverse. At TOP the direction counts as down; at 0 it counts as up.
- R6: In either PWM kind, with action code 10 or 11 and a compare value equal to TOP, the match is ignored. Instead the pin is set (code 10) or cleared (code 11) when the counter is at TOP.
- R7: In either PWM kind, action code 01 toggles channel A's pin on a match only when waveform-mode bit 2 is 1. Otherwise channel A holds. Channel B always holds.
- R8: Compare writes update a holding register. In PWM kinds the active compare value loads from the holding register at the clock edge that leaves TOP. In the other kinds a write reaches the active value at once.
- R9: A pin action takes effect at the clock edge that ends the cycle in which the deciding counter value is present. The pin therefore changes one cycle after the counter shows that value.
- R10: A channel's override output is 1 exactly when its action code is nonzero. Its drive output is 1 exactly when override is 1 and the channel's direction bit is 1. Action code 00 never changes the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_mode | input | 3 | Waveform mode code |
| act_a | input | 2 | Channel A action code |
| act_b | input | 2 | Channel B action code |
| cmp_a_we | input | 1 | Channel A compare write strobe |
| cmp_a_wdata | input | 8 | Channel A compare write data |
| cmp_b_we | input | 1 | Channel B compare write strobe |
| cmp_b_wdata | input | 8 | Channel B compare write data |
| dir_a | input | 1 | Channel A pin direction bit (1 = output) |
| dir_b | input | 1 | Channel B pin direction bit (1 = output) |
| count | output | 8 | Current counter value |
| pin_a | output | 1 | Channel A waveform |
| pin_b | output | 1 | Channel B waveform |
| ovr_a | output | 1 | Channel A owns the pin |
| ovr_b | output | 1 | Channel B owns the pin |
| drv_a | output | 1 | Channel A pin driven |
| drv_b | output | 1 | Channel B pin driven |

## Verification
The bench targets compare values of 0 and compare values equal to TOP in every waveform kind.

- A design that does not ignore the match at TOP would glitch the pin there, or leave it stuck at the wrong level.
- A design that does not keep the match at 0 would miss the one-clock pulse in fast PWM.
- A design that gets the direction wrong at either end of the phase-correct sweep would flip the sense of the duty cycle.
- A design that updates the compare value immediately in PWM kinds would produce a truncated period after a write.
- The bench also applies code 01 in PWM kinds. A design that toggles channel B there, or toggles channel A without mode bit 2, would make the pin oscillate where it must hold.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;

  typedef enum logic [1:0] {
    WK_NORMAL = 2'd0,
    WK_CTC    = 2'd1,
    WK_FAST   = 2'd2,
    WK_PHASE  = 2'd3
  } wave_kind_e;

  typedef enum logic [1:0] {
    PA_HOLD = 2'd0,
    PA_SET  = 2'd1,
    PA_CLR  = 2'd2,
    PA_TGL  = 2'd3
  } pin_act_e;

  function automatic wave_kind_e decode_kind(input logic [2:0] wm);
    case (wm)
      3'b010:          decode_kind = WK_CTC;
      3'b011, 3'b111:  decode_kind = WK_FAST;
      3'b001, 3'b101:  decode_kind = WK_PHASE;
      default:         decode_kind = WK_NORMAL;
    endcase
  endfunction

  function automatic logic top_is_cmp(input logic [2:0] wm);
    top_is_cmp = (wm == 3'b010) || (wm == 3'b111) || (wm == 3'b101);
  endfunction

endpackage

// File: rtl/cmpwave_counter.sv
module cmpwave_counter
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wave_kind_e   kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         at_top
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q;

  always_comb begin
    at_top = (cnt_q == top);
    if (kind == WK_PHASE) begin
      if (at_top)              dir_up = 1'b0;
      else if (cnt_q == ZERO)  dir_up = 1'b1;
      else                     dir_up = up_q;
    end else begin
      dir_up = 1'b1;
    end
  end

  always_comb begin
    case (kind)
      WK_CTC, WK_FAST: cnt_d = at_top ? ZERO : cnt_q + ONE;
      WK_PHASE: begin
        if (top == ZERO)  cnt_d = ZERO;
        else if (dir_up)  cnt_d = cnt_q + ONE;
        else              cnt_d = cnt_q - ONE;
      end
      default:         cnt_d = cnt_q + ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= dir_up;
    end
  end

  assign count = cnt_q;

  // R2: fast PWM wraps to zero after TOP
  a_r2_fast_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_FAST && at_top) |=> (cnt_q == ZERO));

  // R2: phase-correct moves by exactly one step each clock
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_PHASE && top != ZERO) |=>
      ((cnt_q - $past(cnt_q)) == ONE || (cnt_q - $past(cnt_q)) == {W{1'b1}}));

endmodule

// File: rtl/cmpwave_cmpbuf.sv
module cmpwave_cmpbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         load,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] active
);
  logic [W-1:0] hold_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (we) hold_q <= wdata;
      if (!pwm && we)      act_q <= wdata;
      else if (pwm && load) act_q <= hold_q;
    end
  end

  assign active = act_q;

  // R8: in PWM kinds the active value only moves at TOP
  a_r8_hold_between_tops: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load) |=> $stable(act_q));

endmodule

// File: rtl/cmpwave_chan.sv
module cmpwave_chan
  import cmpwave_pkg::*;
#(
  parameter int W      = 8,
  parameter bit CHAN_A = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wave_kind_e   kind,
  input  logic         wm_hi,
  input  logic [1:0]   act_code,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] top,
  input  logic         at_top,
  input  logic         dir_up,
  input  logic         dir_bit,
  output logic         pin,
  output logic         ovr,
  output logic         drv
);
  logic     match;
  logic     may_toggle;
  pin_act_e act;
  logic     pin_q;

  assign match      = (count == cmp);
  assign may_toggle = CHAN_A && wm_hi;

  always_comb begin
    act = PA_HOLD;
    if (act_code != 2'b00) begin
      case (kind)
        WK_NORMAL, WK_CTC: begin
          if (match) begin
            case (act_code)
              2'b01:   act = PA_TGL;
              2'b10:   act = PA_CLR;
              default: act = PA_SET;
            endcase
          end
        end
        WK_FAST: begin
          if (act_code == 2'b01) begin
            if (may_toggle && match) act = PA_TGL;
          end else if (at_top) begin
            act = act_code[0] ? PA_CLR : PA_SET;
          end else if (match) begin
            act = act_code[0] ? PA_SET : PA_CLR;
          end
        end
        default: begin
          if (act_code == 2'b01) begin
            if (may_toggle && match) act = PA_TGL;
          end else if (cmp == top) begin
            if (at_top) act = act_code[0] ? PA_CLR : PA_SET;
          end else if (match) begin
            if (dir_up ^ act_code[0]) act = PA_CLR;
            else                      act = PA_SET;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      case (act)
        PA_SET:  pin_q <= 1'b1;
        PA_CLR:  pin_q <= 1'b0;
        PA_TGL:  pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin = pin_q;
  assign ovr = |act_code;
  assign drv = ovr & dir_bit;

  // R10: no drive without the direction bit
  a_r10_no_drive_without_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_bit |-> !drv);

  // R3: non-PWM kinds hold the pin when there is no match
  a_r3_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == WK_NORMAL || kind == WK_CTC) && !match) |=> $stable(pin_q));

  // R4: non-inverting fast PWM is high after TOP
  a_r4_fast_top_set: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_FAST && act_code == 2'b10 && at_top) |=> pin_q);

  // R10: code 00 leaves the pin alone
  a_r10_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == 2'b00) |=> $stable(pin_q));

endmodule

// File: rtl/cmpwave_timer.sv
module cmpwave_timer
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   wave_mode,
  input  logic [1:0]   act_a,
  input  logic [1:0]   act_b,
  input  logic         cmp_a_we,
  input  logic [W-1:0] cmp_a_wdata,
  input  logic         cmp_b_we,
  input  logic [W-1:0] cmp_b_wdata,
  input  logic         dir_a,
  input  logic         dir_b,
  output logic [W-1:0] count,
  output logic         pin_a,
  output logic         pin_b,
  output logic         ovr_a,
  output logic         ovr_b,
  output logic         drv_a,
  output logic         drv_b
);
  localparam int NCH = 2;

  wave_kind_e   kind;
  logic         pwm;
  logic [W-1:0] top;
  logic [W-1:0] cnt;
  logic         dir_up, at_top;

  logic [NCH-1:0]        ch_we;
  logic [NCH-1:0][W-1:0] ch_wdata;
  logic [NCH-1:0][W-1:0] ch_cmp;
  logic [NCH-1:0][1:0]   ch_code;
  logic [NCH-1:0]        ch_dir;
  logic [NCH-1:0]        ch_pin, ch_ovr, ch_drv;

  assign kind = decode_kind(wave_mode);
  assign pwm  = (kind == WK_FAST) || (kind == WK_PHASE);
  assign top  = top_is_cmp(wave_mode) ? ch_cmp[0] : {W{1'b1}};

  assign ch_we    = {cmp_b_we, cmp_a_we};
  assign ch_wdata = {cmp_b_wdata, cmp_a_wdata};
  assign ch_code  = {act_b, act_a};
  assign ch_dir   = {dir_b, dir_a};

  cmpwave_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .top    (top),
    .count  (cnt),
    .dir_up (dir_up),
    .at_top (at_top)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmpwave_cmpbuf #(.W(W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwm    (pwm),
      .load   (at_top),
      .we     (ch_we[g]),
      .wdata  (ch_wdata[g]),
      .active (ch_cmp[g])
    );

    cmpwave_chan #(.W(W), .CHAN_A(g == 0)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .wm_hi    (wave_mode[2]),
      .act_code (ch_code[g]),
      .count    (cnt),
      .cmp      (ch_cmp[g]),
      .top      (top),
      .at_top   (at_top),
      .dir_up   (dir_up),
      .dir_bit  (ch_dir[g]),
      .pin      (ch_pin[g]),
      .ovr      (ch_ovr[g]),
      .drv      (ch_drv[g])
    );
  end

  assign count = cnt;
  assign pin_a = ch_pin[0];
  assign pin_b = ch_pin[1];
  assign ovr_a = ch_ovr[0];
  assign ovr_b = ch_ovr[1];
  assign drv_a = ch_drv[0];
  assign drv_b = ch_drv[1];

  // R7: channel B never toggles under code 01 in PWM kinds
  a_r7_b_holds_in_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && act_b == 2'b01) |=> $stable(pin_b));

endmodule

// File: tb/tb_cmpwave_timer.sv
module tb_cmpwave_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] wave_mode;
  logic [1:0] act_a, act_b;
  logic       cmp_a_we, cmp_b_we;
  logic [7:0] cmp_a_wdata, cmp_b_wdata;
  logic       dir_a, dir_b;
  logic [7:0] count;
  logic       pin_a, pin_b, ovr_a, ovr_b, drv_a, drv_b;

  int n_vec = 0;
  int n_bad = 0;

  // model state
  int m_cnt, m_hold_a, m_hold_b, m_act_a, m_act_b;
  bit m_up, m_pa, m_pb;

  always #10 clk = ~clk;

  cmpwave_timer dut (
    .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .act_a(act_a), .act_b(act_b),
    .cmp_a_we(cmp_a_we), .cmp_a_wdata(cmp_a_wdata), .cmp_b_we(cmp_b_we),
    .cmp_b_wdata(cmp_b_wdata), .dir_a(dir_a), .dir_b(dir_b), .count(count),
    .pin_a(pin_a), .pin_b(pin_b), .ovr_a(ovr_a), .ovr_b(ovr_b),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  // 0 = normal/CTC, 1 = fast, 2 = phase-correct (R2 encodings)
  function automatic int kind_of(input logic [2:0] wm);
    if (wm == 3'b011 || wm == 3'b111) return 1;
    if (wm == 3'b001 || wm == 3'b101) return 2;
    return 0;
  endfunction

  function automatic int top_of(input logic [2:0] wm, input int cmpa);
    if (wm == 3'b010 || wm == 3'b111 || wm == 3'b101) return cmpa;
    return 255;
  endfunction

  // 0 hold, 1 set, 2 clear, 3 toggle
  function automatic int exp_act(input int k, input logic [1:0] c, input int cnt,
                                 input int cmp, input int top, input bit up,
                                 input bit isa, input bit wm2);
    if (c == 2'b00) return 0;                           // R10
    if (k == 0) begin                                   // R3
      if (cnt != cmp) return 0;
      return (c == 2'b01) ? 3 : (c == 2'b10) ? 2 : 1;
    end
    if (c == 2'b01) return (isa && wm2 && cnt == cmp) ? 3 : 0;   // R7
    if (k == 1) begin                                   // R4
      if (cnt == top) return (c == 2'b10) ? 1 : 2;
      if (cnt == cmp) return (c == 2'b10) ? 2 : 1;
      return 0;
    end
    if (cmp == top) return (cnt == top) ? ((c == 2'b10) ? 1 : 2) : 0;  // R6
    if (cnt != cmp) return 0;
    return (up ^ (c == 2'b11)) ? 2 : 1;                 // R5
  endfunction

  function automatic bit apply(input bit p, input int a);
    case (a)
      1: return 1'b1;
      2: return 1'b0;
      3: return ~p;
      default: return p;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] wm, input logic [1:0] c,
                                    input int cmp);
    int k = kind_of(wm);
    if (c == 2'b00) return "R10";
    if (k == 0) return "R3";
    if (c == 2'b01) return "R7";
    if (cmp == top_of(wm, m_act_a)) return "R6";
    return (k == 1) ? "R4" : "R5";
  endfunction

  // advance the model across the coming clock edge with the inputs now applied
  task automatic model_step();
    int k, top, nc, aa, ab;
    bit at, up, pwm;
    k   = kind_of(wave_mode);
    pwm = (k != 0);
    top = top_of(wave_mode, m_act_a);
    at  = (m_cnt == top);
    if (k == 2) up = at ? 1'b0 : (m_cnt == 0) ? 1'b1 : m_up;
    else up = 1'b1;
    aa = exp_act(k, act_a, m_cnt, m_act_a, top, up, 1'b1, wave_mode[2]);
    ab = exp_act(k, act_b, m_cnt, m_act_b, top, up, 1'b0, wave_mode[2]);
    if (k == 2) nc = (top == 0) ? 0 : up ? (m_cnt + 1) % 256 : (m_cnt + 255) % 256;
    else if (wave_mode == 3'b010 || k == 1) nc = at ? 0 : (m_cnt + 1) % 256;
    else nc = (m_cnt + 1) % 256;
    // R8 double buffering
    if (!pwm && cmp_a_we) m_act_a = cmp_a_wdata;
    else if (pwm && at)   m_act_a = m_hold_a;
    if (!pwm && cmp_b_we) m_act_b = cmp_b_wdata;
    else if (pwm && at)   m_act_b = m_hold_b;
    if (cmp_a_we) m_hold_a = cmp_a_wdata;
    if (cmp_b_we) m_hold_b = cmp_b_wdata;
    m_pa  = apply(m_pa, aa);
    m_pb  = apply(m_pb, ab);
    m_cnt = nc;
    m_up  = up;
  endtask

  task automatic check_bit(input string req, input string what, input bit act, input bit exp);
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 30)
        $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // called at a falling edge: compares outputs with the model
  task automatic check_all();
    n_vec++;
    if (count !== 8'(m_cnt)) begin
      n_bad++;
      if (n_bad < 30)
        $display("FAIL R2 count actual=%0d expected=%0d t=%0t", count, m_cnt, $time);
    end
    // R9 timing and R8 buffering show up through the pin comparisons
    check_bit(tag_for(wave_mode, act_a, m_act_a), "pin_a", pin_a, m_pa);
    check_bit(tag_for(wave_mode, act_b, m_act_b), "pin_b", pin_b, m_pb);
    check_bit("R10", "ovr_a", ovr_a, act_a != 2'b00);
    check_bit("R10", "ovr_b", ovr_b, act_b != 2'b00);
    check_bit("R10", "drv_a", drv_a, (act_a != 2'b00) && dir_a);
    check_bit("R10", "drv_b", drv_b, (act_b != 2'b00) && dir_b);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      cmp_a_we = 1'b0;
      cmp_b_we = 1'b0;
      model_step();
    end
  endtask

  task automatic write_both(input int a, input int b);
    @(negedge clk);
    check_all();
    cmp_a_we = 1'b1; cmp_a_wdata = 8'(a);
    cmp_b_we = 1'b1; cmp_b_wdata = 8'(b);
    model_step();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [2:0] wms [6] = '{3'b000, 3'b010, 3'b011, 3'b111, 3'b001, 3'b101};
    int seed_set;
    seed_set = $urandom(32'h1F2E3D4C);
    rst_n = 1'b0; wave_mode = 3'b000; act_a = 2'b00; act_b = 2'b00;
    cmp_a_we = 1'b0; cmp_b_we = 1'b0; cmp_a_wdata = '0; cmp_b_wdata = '0;
    dir_a = 1'b0; dir_b = 1'b0;
    m_cnt = 0; m_up = 1'b1; m_pa = 1'b0; m_pb = 1'b0;
    m_hold_a = 0; m_hold_b = 0; m_act_a = 0; m_act_b = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all();
    @(negedge clk);
    rst_n = 1'b1;
    model_step();

    // directed: every waveform mode x every action code x compare corner
    for (int w = 0; w < 6; w++) begin
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < 3; s++) begin
          bit ocr_top;
          int va, vb;
          ocr_top = (wms[w] == 3'b010 || wms[w] == 3'b111 || wms[w] == 3'b101);
          case (s)
            0: begin va = ocr_top ? 8'h80 : 8'h00; vb = 0; end         // compare 0
            1: begin va = ocr_top ? 200 : 255; vb = va; end            // R6 compare = TOP
            default: begin va = ocr_top ? 8'h60 : 8'h33; vb = 8'h47; end
          endcase
          @(negedge clk);
          check_all();
          wave_mode = wms[w];
          act_a = 2'(c); act_b = 2'(c);
          dir_a = 1'($urandom_range(0, 1)); dir_b = 1'($urandom_range(0, 1));
          model_step();
          write_both(va, vb);
          run(560);
        end
      end
    end

    // directed R2 corner: phase-correct with TOP of zero stays at zero
    @(negedge clk);
    check_all();
    wave_mode = 3'b101; act_a = 2'b10; act_b = 2'b11;
    model_step();
    write_both(0, 0);
    run(600);

    // constrained random segments with occasional compare writes (R8)
    for (int seg = 0; seg < 40; seg++) begin
      int len;
      @(negedge clk);
      check_all();
      wave_mode = 3'($urandom_range(0, 7));
      act_a = 2'($urandom_range(0, 3)); act_b = 2'($urandom_range(0, 3));
      dir_a = 1'($urandom_range(0, 1)); dir_b = 1'($urandom_range(0, 1));
      model_step();
      len = $urandom_range(300, 900);
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        check_all();
        cmp_a_we = ($urandom_range(0, 63) == 0);
        cmp_b_we = ($urandom_range(0, 63) == 0);
        cmp_a_wdata = 8'($urandom_range(0, 255));
        cmp_b_wdata = ($urandom_range(0, 3) == 0) ? cmp_a_wdata : 8'($urandom_range(0, 255));
        model_step();
      end
    end
    run(2);
    summary();
  end
endmodule